// File: doc/BRIEF.md
# Serial Port Baud Clock Generator

This block produces the bit-timing strobes for a serial port transmitter and receiver. A reloading 12-bit down-counter divides the system clock by (divisor + 1). Its tick is the receiver base rate in asynchronous operation. It also feeds a fixed chain of a halving stage, a quartering stage and a final halving stage, which gives the transmit rate. All outputs are single-cycle enables in the system clock domain. No derived clock leaves the block.

Four clocking modes are supported. Normal asynchronous sends at 1/16 of the tick rate. Double-speed asynchronous skips the last halving stage, so it sends at 1/8 of the tick rate. Synchronous master drives a square wave on the clock pin and takes both enables from its edges. Synchronous slave passes the external clock pin through a two-stage synchroniser and an edge detector, then takes both enables from its edges. A polarity bit chooses which clock edge launches transmit data and which one samples receive data.

Top module: `baud_clkgen`

## Requirements
- R1: While rst_ni is low, tx_en_o, rx_en_o and xck_o are all 0.
- R2: In both asynchronous modes (sync_mode_i=0), rx_en_o pulses once for every prescaler tick. The ticks come every baud_div_i+1 cycles, and the first tick follows reset at once. With divisor 0, rx_en_o is high on every cycle.
- R3: In normal asynchronous mode (dbl_speed_i=0), tx_en_o is high on every 16th prescaler tick, counted from reset.
- R4: In double-speed asynchronous mode (dbl_speed_i=1), tx_en_o is high on every 8th prescaler tick, counted from reset.
- R5: dbl_speed_i has no effect while sync_mode_i=1.
- R6: A cycle with baud_wr_i=1 loads the down-counter with baud_div_i and produces no tick in that cycle. The next tick follows baud_div_i+1 cycles later.
- R7: In master mode (sync_mode_i=1, xck_dir_i=1), xck_o toggles on every prescaler tick. It goes high on the first tick after reset, so its period is 2*(baud_div_i+1) cycles.
- R8: xck_o is 0 in both asynchronous modes and in slave mode (sync_mode_i=1, xck_dir_i=0).
- R9: In slave mode, xck_i is sampled by two register stages and then compared with one more stage. An edge on xck_i that is sampled at clock edge k gives its enable pulse in the cycle after clock edge k+2.
- R10: In both synchronous modes, with xck_pol_i=0, tx_en_o marks rising clock edges and rx_en_o marks falling edges. With xck_pol_i=1 the two are swapped.
- R11: In the synchronous modes, tx_en_o and rx_en_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | 12 | Baud divisor; tick rate is clk/(value+1) |
| baud_wr_i | input | 1 | Divisor write strobe; reloads the down-counter |
| dbl_speed_i | input | 1 | Skip the final halving stage (asynchronous only) |
| sync_mode_i | input | 1 | 0 asynchronous, 1 synchronous |
| xck_dir_i | input | 1 | In synchronous mode: 1 master, 0 slave |
| xck_pol_i | input | 1 | Swaps the edges used for transmit and receive |
| xck_i | input | 1 | External clock pin input |
| tx_en_o | output | 1 | Transmit bit enable |
| rx_en_o | output | 1 | Receive base enable |
| xck_o | output | 1 | Generated clock pin output |

## Verification
The bench drives each of the four modes with random small divisors and with both polarities. It also drives the double-speed bit in both states, so a mode that reads the wrong divider tap shows up as a shifted or missing pulse. Divisor writes are injected at random points in the count, to tell an immediate reload apart from one that waits for the current count to end. In slave mode, the external clock toggles with random hold times so that the bench can check the synchroniser latency. Directed segments cover divisor 0, where a tick comes on every cycle, and the largest divisor in master mode.

// File: rtl/baud_clkgen_pkg.sv
`timescale 1ns/1ps
package baud_clkgen_pkg;
  typedef enum logic [1:0] {
    CLK_ASYNC    = 2'd0,
    CLK_ASYNC_X2 = 2'd1,
    CLK_MASTER   = 2'd2,
    CLK_SLAVE    = 2'd3
  } clk_mode_e;

  function automatic clk_mode_e decode_mode(input logic sync, input logic dir, input logic dbl);
    if (sync) return dir ? CLK_MASTER : CLK_SLAVE;
    return dbl ? CLK_ASYNC_X2 : CLK_ASYNC;
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
`timescale 1ns/1ps
module baud_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i || cnt_q == '0)   cnt_q <= div_i;
    else                              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/baud_div_chain.sv
`timescale 1ns/1ps
module baud_div_chain #(
  parameter int MID_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic half_lvl_o,
  output logic half_rise_o,
  output logic half_fall_o,
  output logic mid_o,
  output logic full_o
);
  localparam int MID_W = (MID_DIV > 2) ? $clog2(MID_DIV) : 1;
  localparam logic [MID_W-1:0] MID_LAST = MID_W'(MID_DIV - 1);

  logic             half_q, last_q;
  logic [MID_W-1:0] mid_q;
  logic             half_en;

  assign half_rise_o = tick_i && !half_q;
  assign half_fall_o = tick_i && half_q;
  assign half_en     = half_fall_o;
  assign mid_o       = half_en && (mid_q == MID_LAST);
  assign full_o      = mid_o && last_q;
  assign half_lvl_o  = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      mid_q  <= '0;
      last_q <= 1'b0;
    end else begin
      if (tick_i)  half_q <= !half_q;
      if (half_en) mid_q  <= (mid_q == MID_LAST) ? '0 : mid_q + 1'b1;
      if (mid_o)   last_q <= !last_q;
    end
  end
endmodule

// File: rtl/baud_xck_sync.sv
`timescale 1ns/1ps
module baud_xck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xck_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= xck_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] && !prev_q;
  assign fall_o = !sync_q[STAGES-1] && prev_q;
endmodule

// File: rtl/baud_clkgen.sv
`timescale 1ns/1ps
module baud_clkgen
  import baud_clkgen_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int MID_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             baud_wr_i,
  input  logic             dbl_speed_i,
  input  logic             sync_mode_i,
  input  logic             xck_dir_i,
  input  logic             xck_pol_i,
  input  logic             xck_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             xck_o
);
  clk_mode_e mode;
  logic tick, half_lvl, half_rise, half_fall, mid_tap, full_tap;
  logic ext_rise, ext_fall;
  logic tx_nx, rx_nx, tx_q, rx_q;

  assign mode = decode_mode(sync_mode_i, xck_dir_i, dbl_speed_i);

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .div_i(baud_div_i), .load_i(baud_wr_i), .tick_o(tick)
  );

  baud_div_chain #(.MID_DIV(MID_DIV)) u_div (
    .clk_i, .rst_ni, .tick_i(tick),
    .half_lvl_o(half_lvl), .half_rise_o(half_rise), .half_fall_o(half_fall),
    .mid_o(mid_tap), .full_o(full_tap)
  );

  baud_xck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .xck_i, .rise_o(ext_rise), .fall_o(ext_fall)
  );

  always_comb begin
    tx_nx = 1'b0;
    rx_nx = 1'b0;
    unique case (mode)
      CLK_ASYNC:    begin tx_nx = full_tap; rx_nx = tick; end
      CLK_ASYNC_X2: begin tx_nx = mid_tap;  rx_nx = tick; end
      CLK_MASTER:   begin
        tx_nx = xck_pol_i ? half_fall : half_rise;
        rx_nx = xck_pol_i ? half_rise : half_fall;
      end
      CLK_SLAVE:    begin
        tx_nx = xck_pol_i ? ext_fall : ext_rise;
        rx_nx = xck_pol_i ? ext_rise : ext_fall;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_nx;
      rx_q <= rx_nx;
    end
  end

  assign tx_en_o = tx_q;
  assign rx_en_o = rx_q;
  // pin driven only in synchronous master mode
  assign xck_o   = (mode == CLK_MASTER) && half_lvl;
endmodule

// File: rtl/baud_clkgen_chk.sv
`timescale 1ns/1ps
module baud_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_mode_i,
  input logic xck_dir_i,
  input logic xck_pol_i,
  input logic tx_en_o,
  input logic rx_en_o,
  input logic xck_o
);
  logic master;
  assign master = sync_mode_i && xck_dir_i;

  p_rst_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_en_o && !rx_en_o && !xck_o));

  p_pin_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master |-> !xck_o);

  p_excl_sync_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |=> !(tx_en_o && rx_en_o));

  p_rise_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master && $past(master) && !$past(xck_pol_i) && $rose(xck_o)) |-> tx_en_o);

  p_fall_rx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master && $past(master) && !$past(xck_pol_i) && $fell(xck_o)) |-> rx_en_o);
endmodule

bind baud_clkgen baud_clkgen_chk u_chk (
  .clk_i, .rst_ni, .sync_mode_i, .xck_dir_i, .xck_pol_i, .tx_en_o, .rx_en_o, .xck_o
);

// File: tb/tb_baud_clkgen.sv
`timescale 1ns/1ps
module tb_baud_clkgen;
  localparam int DIV_W = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [DIV_W-1:0] baud_div_i = '0;
  logic baud_wr_i = 0, dbl_speed_i = 0, sync_mode_i = 0, xck_dir_i = 0, xck_pol_i = 0, xck_i = 0;
  logic tx_en_o, rx_en_o, xck_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  int      m_cnt = 0;
  longint  m_n = 0;
  logic    h1 = 0, h2 = 0, h3 = 0;  // xck_i sampled at the last three edges
  int      wr_age = 100000;

  always #2 clk_i = !clk_i;

  baud_clkgen dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic tick, etx, erx, exck, rise, fall;
    string ttx, trx, tpin;
    tick = !baud_wr_i && (m_cnt == 0);
    if (tick) m_n++;
    etx = 0; erx = 0; exck = 0;
    ttx = "R3"; trx = "R2"; tpin = "R8";
    if (!sync_mode_i) begin
      erx = tick;
      etx = tick && ((m_n % (dbl_speed_i ? 8 : 16)) == 0);
      ttx = dbl_speed_i ? "R4" : "R3";
    end else if (xck_dir_i) begin
      rise = tick && (m_n % 2 == 1);
      fall = tick && (m_n % 2 == 0);
      etx = xck_pol_i ? fall : rise;
      erx = xck_pol_i ? rise : fall;
      exck = (m_n % 2 == 1);
      tpin = "R7";
      ttx = dbl_speed_i ? "R5" : "R10";
      trx = "R10";
    end else begin
      rise = h2 && !h3;
      fall = !h2 && h3;
      etx = xck_pol_i ? fall : rise;
      erx = xck_pol_i ? rise : fall;
      ttx = "R9"; trx = xck_pol_i ? "R10" : "R9";
    end
    if (baud_wr_i) wr_age = 0; else wr_age++;
    if (wr_age <= int'(baud_div_i) + 1 && !(sync_mode_i && !xck_dir_i)) trx = "R6";
    if (baud_wr_i || m_cnt == 0) m_cnt = int'(baud_div_i); else m_cnt--;
    h3 = h2; h2 = h1; h1 = xck_i;
    @(posedge clk_i);
    #1;
    chk(ttx, tx_en_o, etx);
    chk(trx, rx_en_o, erx);
    chk(tpin, xck_o, exck);
    if (sync_mode_i) begin
      checks++;
      if (tx_en_o && rx_en_o) begin
        fails++;
        $display("FAIL R11: actual tx=1 rx=1 expected not both at %0t", $time);
      end
    end
  endtask

  task automatic segment(input logic s, input logic d, input logic dbl, input logic p,
                         input int div, input int cycles, input bit rnd_wr);
    sync_mode_i = s; xck_dir_i = d; dbl_speed_i = dbl; xck_pol_i = p;
    baud_div_i = DIV_W'(div);
    for (int i = 0; i < cycles; i++) begin
      baud_wr_i = rnd_wr && ($urandom_range(0, 40) == 0);
      if (s && !d && $urandom_range(0, 2) == 0) xck_i = !xck_i;
      step();
    end
    baud_wr_i = 0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", tx_en_o, 1'b0);
    chk("R1", rx_en_o, 1'b0);
    chk("R1", xck_o, 1'b0);
    rst_ni = 1;
    // directed: divisor 0 ticks every cycle
    segment(0, 0, 0, 0, 0, 64, 0);
    segment(0, 0, 1, 0, 0, 64, 0);
    // directed: write mid-count with a new divisor
    segment(0, 0, 0, 0, 9, 25, 0);
    baud_div_i = 3; baud_wr_i = 1; step(); baud_wr_i = 0;
    segment(0, 0, 0, 0, 3, 40, 0);
    // directed: largest divisor in master mode
    segment(1, 1, 0, 0, 4095, 8300, 0);
    // directed: double-speed ignored in sync modes
    segment(1, 1, 1, 0, 2, 200, 0);
    segment(1, 0, 1, 1, 2, 200, 0);
    // random segments
    for (int k = 0; k < 60; k++)
      segment($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 6), $urandom_range(50, 400), 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule